// File: doc/BRIEF.md
# Bus Cycle Type Statistics Unit

This block watches the two memory-access control strobes of a single-bus processor interface: the sequential flag and the active-low memory-request flag. It places every bus clock into one of four classes: sequential transfer, non-sequential transfer, internal (no transfer) or coprocessor. It keeps a running count of each class and a count of all clocks. It also counts every internal clock that is followed directly by a sequential clock. Such a merged pair matters to a memory controller that starts decoding the address during the idle clock.

A one-clock command opens a reference window. A second set of counters restarts from zero and counts the same events. The cumulative set is not disturbed. Either set is read by presenting a 4-bit index. The selected value appears on a registered output one clock later. All counters saturate at all-ones.

Top module: `bus_cycle_stats`

## Requirements
- R1: Each clock is decoded from {seq_i, mreq_n_i}: 2'b10 sequential, 2'b00 non-sequential, 2'b11 internal, 2'b01 coprocessor. The matching cumulative counter (index 0, 1, 2, 3 respectively) advances by one.
- R2: The cumulative total counter (index 5) advances on every clock out of reset, so it equals the sum of indices 0 to 3.
- R3: A sequential clock whose immediately preceding clock was internal also advances the merged counter (index 4).
- R4: Reset (synchronous, active high) clears every counter, the read register and the internal-history flag. The first clock after reset is therefore never counted as merged, even when reset was held with internal strobes.
- R5: A clock with ref_take_i high loads zero into the reference set (indices 8 to 13, same order as 0 to 5). That clock is not counted in the reference set. The cumulative set still counts it, and the reference set counts every later clock.
- R6: Every counter holds at all-ones instead of wrapping.
- R7: rd_data_o takes the value the indexed counter held before the clock edge at which the index was sampled. Indices 6, 7, 14 and 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_i | input | 1 | Sequential strobe of the bus |
| mreq_n_i | input | 1 | Active-low memory request strobe |
| ref_take_i | input | 1 | Restart the reference counter set from zero |
| rd_idx_i | input | 4 | Counter select: bit 3 picks the reference set, bits 2:0 the counter |
| rd_data_o | output | CNT_W | Selected counter value, registered |

## Verification
A wrong decode or a stale history flag shows at the ports as a class count or merged count that disagrees with the bench model. It is visible on the first read of that index after the faulty clock, one cycle after the index is presented. A reference clear that touches the cumulative set appears as a drop in index 5 on its next read. A second instance with 4-bit counters reaches saturation within a few dozen clocks, so a counter that wraps is caught early in the run.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // event slots shared by both counter sets; readback index bits 2:0
  localparam int EV_S   = 0;
  localparam int EV_N   = 1;
  localparam int EV_I   = 2;
  localparam int EV_C   = 3;
  localparam int EV_IS  = 4;
  localparam int EV_TOT = 5;
  localparam int NUM_EV = 6;

  // encoding is {seq, mreq_n}
  typedef enum logic [1:0] {
    CYC_N = 2'b00,
    CYC_C = 2'b01,
    CYC_S = 2'b10,
    CYC_I = 2'b11
  } cyc_kind_t;
endpackage

// File: rtl/bcs_classify.sv
module bcs_classify
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_i,
  input  logic              mreq_n_i,
  output logic [NUM_EV-1:0] hit_o
);
  cyc_kind_t kind;
  logic      prev_int_q;

  assign kind = cyc_kind_t'({seq_i, mreq_n_i});

  always_ff @(posedge clk) begin
    if (rst) prev_int_q <= 1'b0;
    else     prev_int_q <= (kind == CYC_I);
  end

  always_comb begin
    hit_o         = '0;
    hit_o[EV_S]   = (kind == CYC_S);
    hit_o[EV_N]   = (kind == CYC_N);
    hit_o[EV_I]   = (kind == CYC_I);
    hit_o[EV_C]   = (kind == CYC_C);
    hit_o[EV_IS]  = (kind == CYC_S) && prev_int_q;
    hit_o[EV_TOT] = 1'b1;
  end
endmodule

// File: rtl/bcs_sat_counter.sv
module bcs_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i)              cnt_o <= '0;
    else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bcs_readback.sv
module bcs_readback
  import bcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [3:0]                   idx_i,
  input  logic [NUM_EV-1:0][CNT_W-1:0] cum_i,
  input  logic [NUM_EV-1:0][CNT_W-1:0] ref_i,
  output logic [CNT_W-1:0]             data_o
);
  logic [CNT_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_EV; k++) begin
      if (idx_i[2:0] == 3'(k)) sel = idx_i[3] ? ref_i[k] : cum_i[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= sel;
  end
endmodule

// File: rtl/bus_cycle_stats.sv
module bus_cycle_stats
  import bcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seq_i,
  input  logic             mreq_n_i,
  input  logic             ref_take_i,
  input  logic [3:0]       rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [NUM_EV-1:0]            hit;
  logic [NUM_EV-1:0][CNT_W-1:0] cum_q;
  logic [NUM_EV-1:0][CNT_W-1:0] ref_q;

  bcs_classify u_cls (
    .clk(clk), .rst(rst), .seq_i(seq_i), .mreq_n_i(mreq_n_i), .hit_o(hit)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    bcs_sat_counter #(.CNT_W(CNT_W)) u_cum (
      .clk(clk), .rst(rst), .clr_i(1'b0), .inc_i(hit[g]), .cnt_o(cum_q[g])
    );
    bcs_sat_counter #(.CNT_W(CNT_W)) u_ref (
      .clk(clk), .rst(rst), .clr_i(ref_take_i), .inc_i(hit[g]), .cnt_o(ref_q[g])
    );
  end

  bcs_readback #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .idx_i(rd_idx_i), .cum_i(cum_q), .ref_i(ref_q),
    .data_o(rd_data_o)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         seq_i,
  input logic                         mreq_n_i,
  input logic                         ref_take_i,
  input logic [3:0]                   rd_idx_i,
  input logic [CNT_W-1:0]             rd_data_o,
  input logic [NUM_EV-1:0][CNT_W-1:0] cum_q,
  input logic [NUM_EV-1:0][CNT_W-1:0] ref_q
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R2: total advances every clock until saturated
  a_r2_total_step: assert property (@(posedge clk) disable iff (rst)
    (cum_q[EV_TOT] != TOP) |=> cum_q[EV_TOT] == $past(cum_q[EV_TOT]) + 1'b1);

  // R1: a sequential clock advances the sequential count
  a_r1_seq_count: assert property (@(posedge clk) disable iff (rst)
    (seq_i && !mreq_n_i && cum_q[EV_S] != TOP) |=> cum_q[EV_S] == $past(cum_q[EV_S]) + 1'b1);

  // R3: internal then sequential advances the merged count
  a_r3_merged: assert property (@(posedge clk) disable iff (rst)
    (seq_i && mreq_n_i) ##1 (seq_i && !mreq_n_i && cum_q[EV_IS] != TOP)
      |=> cum_q[EV_IS] == $past(cum_q[EV_IS]) + 1'b1);

  // R4: reset empties the read register
  a_r4_reset_read: assert property (@(posedge clk) rst |=> rd_data_o == '0);

  // R5: reference take zeroes the reference total
  a_r5_ref_clear: assert property (@(posedge clk) disable iff (rst)
    ref_take_i |=> ref_q[EV_TOT] == '0);

  // R6: a saturated counter stays put
  a_r6_hold_top: assert property (@(posedge clk) disable iff (rst)
    (cum_q[EV_TOT] == TOP) |=> cum_q[EV_TOT] == TOP);

  // R7: reading the total returns the value held one clock earlier
  a_r7_read_latency: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_i == 4'd5) |=> rd_data_o == $past(cum_q[EV_TOT]));
endmodule

bind bus_cycle_stats bcs_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_bus_cycle_stats.sv
module sim_bus_cycle_stats;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seq = 1'b1, mreq_n = 1'b1, ref_take = 1'b0;
  logic [3:0]  idx = 4'd0;
  logic [31:0] rd0;
  logic [3:0]  rd1;

  int errors = 0;
  int checks = 0;

  int unsigned cum_m[6];
  int unsigned ref_m[6];
  bit          prev_int;

  always #5 clk = ~clk;

  bus_cycle_stats u0 (.clk(clk), .rst(rst), .seq_i(seq), .mreq_n_i(mreq_n),
    .ref_take_i(ref_take), .rd_idx_i(idx), .rd_data_o(rd0));
  // narrow instance for saturation (R6)
  bus_cycle_stats #(.CNT_W(4)) u1 (.clk(clk), .rst(rst), .seq_i(seq), .mreq_n_i(mreq_n),
    .ref_take_i(ref_take), .rd_idx_i(idx), .rd_data_o(rd1));

  function automatic int unsigned expv(logic [3:0] i);
    if (i[2:0] > 3'd5) return 0;
    return i[3] ? ref_m[i[2:0]] : cum_m[i[2:0]];
  endfunction

  function automatic string tag_of(logic [3:0] i);
    if (i[2:0] > 3'd5) return "R7";
    if (i[3])          return "R5";
    if (i[2:0] == 3'd4) return "R3";
    if (i[2:0] == 3'd5) return "R2";
    return "R1";
  endfunction

  function automatic void model_step(bit s, bit mn, bit rf);
    bit h[6];
    h[0] = s & ~mn; h[1] = ~s & ~mn; h[2] = s & mn; h[3] = ~s & mn;
    h[4] = h[0] & prev_int; h[5] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cum_m[k] += h[k];
      ref_m[k] = rf ? 0 : ref_m[k] + h[k];
    end
    prev_int = h[2];
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic tick(bit s, bit mn, bit rf, logic [3:0] i);
    int unsigned e;
    seq = s; mreq_n = mn; ref_take = rf; idx = i;
    e = expv(i);
    @(posedge clk);
    model_step(s, mn, rf);
    @(negedge clk);
    check(tag_of(i), rd0, e);
    check((e >= 15) ? "R6" : tag_of(i), rd1, (e > 15) ? 15 : e);
  endtask

  task automatic do_reset();
    rst = 1'b1; seq = 1'b1; mreq_n = 1'b1; ref_take = 1'b0;
    repeat (3) @(posedge clk);
    for (int k = 0; k < 6; k++) begin cum_m[k] = 0; ref_m[k] = 0; end
    prev_int = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R4", rd0, 0);
    check("R4", rd1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    // R4: reset held with internal strobes, first clock sequential: not merged
    tick(1, 0, 0, 4'd4);
    tick(1, 0, 0, 4'd4);   // reads merged after that clock: 0
    tick(1, 1, 0, 4'd0);
    // R3: internal then sequential
    tick(1, 0, 0, 4'd4);
    tick(0, 0, 0, 4'd4);
    // R1: each class
    tick(0, 1, 0, 4'd1);
    tick(0, 0, 0, 4'd3);
    tick(1, 1, 0, 4'd1);
    tick(1, 1, 0, 4'd2);
    tick(1, 0, 0, 4'd2);
    // R7: unused indices
    tick(1, 0, 0, 4'd6);
    tick(1, 0, 0, 4'd15);
    // R5: reference take, then read reference and cumulative totals
    tick(1, 1, 1, 4'd5);
    tick(1, 0, 0, 4'd13);
    tick(1, 0, 0, 4'd13);
    tick(1, 0, 0, 4'd5);
    tick(1, 0, 0, 4'd12);
    // R6 through the narrow instance, and random mix
    for (int n = 0; n < 4000; n++) begin
      bit s, mn, rf;
      s  = ($urandom % 3) != 0;
      mn = $urandom % 2;
      rf = ($urandom % 50) == 0;
      tick(s, mn, rf, 4'($urandom % 16));
    end
    // reset mid-run clears everything (R4)
    do_reset();
    for (int k = 0; k < 16; k++) tick(0, 0, 0, 4'(k));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule